// File: doc/BRIEF.md
# Serial Add-Three Unit

This block adds the constant three to a 4-bit unsigned number that arrives one bit per clock on a single input line, least significant bit first. Each sum bit is produced combinationally in the same cycle as the input bit it belongs to, also least significant bit first. The state moves on the falling edge of the clock. On the last bit of a word an overflow flag rises when the true sum is larger than fifteen; the sum bit on that cycle is still the correct low-order bit.

The machine keeps seven states that encode which bit of the word comes next and the carry held from the bits already seen. After the fourth bit it falls back to its start state without outside help, so words can follow each other with no gap. A synchronous active-high reset, sampled on the falling edge, forces the start state and drops any partial word.

Top module: `addthree_serial`

## Requirements
- R1: While `rst` is 1 at a falling clock edge the machine enters its start state; with `din` = 0 in the following cycle `sum_bit` = 1 and `ovf` = 0.
- R2: On the first bit of every word `sum_bit` equals the inverse of `din` and `ovf` is 0.
- R3: The four `sum_bit` values of a word, taken with the first as bit 0, form (N + 3) mod 16, where N is the word on `din` with its first bit as bit 0.
- R4: On the fourth bit of a word `ovf` is 1 when N is 13, 14 or 15 and 0 for every other N.
- R5: `ovf` is 0 on the first, second and third bits of every word.
- R6: After the fourth bit the machine starts a new word at the next bit with no reset; back-to-back words each obey R3 and R4.
- R7: `sum_bit` and `ovf` follow a change of `din` within the same cycle, and a rising clock edge does not advance the state.
- R8: A reset in the middle of a word discards the bits already received; the next word is handled as if it were the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on its falling edge |
| rst | input | 1 | Synchronous reset, active high, sampled on the falling edge |
| din | input | 1 | Serial operand, least significant bit first |
| sum_bit | output | 1 | Serial sum bit for the present `din` |
| ovf | output | 1 | Overflow flag, meaningful on the fourth bit of a word |
| state_q | output | 3 | Present state encoding (start state is 0) |

## Verification
Both outputs are combinational from the present state and `din`, so each result is due in the very cycle its input bit is presented, before the falling edge that consumes the bit. The bench sets `din` just after a falling edge, reads `sum_bit` and `ovf` just after the following rising edge, and lets the next falling edge advance the state; the state is therefore one falling edge behind the input it absorbed. For R7 `din` is changed between the rising edge and the falling edge and the outputs are read again in that same half cycle.

// File: rtl/addthree_pkg.sv
package addthree_pkg;

    localparam int WORD_BITS = 4;
    localparam int ADDEND    = 3;
    localparam int STATE_W   = 3;
    localparam int POS_W     = $clog2(WORD_BITS);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_BITS - 1);

    typedef enum logic [STATE_W-1:0] {
        ST_P0    = 3'd0,
        ST_P1_C0 = 3'd1,
        ST_P1_C1 = 3'd2,
        ST_P2_C0 = 3'd3,
        ST_P2_C1 = 3'd4,
        ST_P3_C0 = 3'd5,
        ST_P3_C1 = 3'd6
    } state_t;

    typedef struct packed {
        logic             legal;
        logic [POS_W-1:0] pos;
        logic             cin;
        logic             sum;
        logic             cout;
    } step_t;

    typedef struct packed {
        logic sum;
        logic ovf;
    } out_t;

    function automatic logic addend_bit(input logic [POS_W-1:0] pos);
        logic [WORD_BITS-1:0] k;
        k = WORD_BITS'(ADDEND);
        return k[pos];
    endfunction

    function automatic state_t make_state(input logic [POS_W-1:0] pos, input logic carry);
        state_t s;
        if (pos == '0) s = ST_P0;
        else s = state_t'(STATE_W'(2 * int'(pos) - 1 + int'(carry)));
        return s;
    endfunction

    function automatic step_t bit_step(input logic [STATE_W-1:0] st, input logic d);
        step_t r;
        logic  ab;
        r = '0;
        if (st == ST_P0) begin
            r.legal = 1'b1;
        end else if (st <= ST_P3_C1) begin
            r.legal = 1'b1;
            r.pos   = POS_W'((int'(st) + 1) / 2);
            r.cin   = ~st[0];
        end
        ab = addend_bit(r.pos);
        {r.cout, r.sum} = {1'b0, d} + {1'b0, ab} + {1'b0, r.cin};
        if (!r.legal) begin
            r.sum  = 1'b0;
            r.cout = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/addthree_nsl.sv
module addthree_nsl
    import addthree_pkg::*;
(
    input  logic [STATE_W-1:0] cur,
    input  logic               din,
    output logic [STATE_W-1:0] nxt
);
    step_t stp;

    always_comb begin
        stp = bit_step(cur, din);
        if (!stp.legal || stp.pos == LAST_POS) nxt = ST_P0;
        else nxt = make_state(stp.pos + POS_W'(1), stp.cout);
    end
endmodule

// File: rtl/addthree_outl.sv
module addthree_outl
    import addthree_pkg::*;
(
    input  logic [STATE_W-1:0] cur,
    input  logic               din,
    output out_t               res
);
    step_t stp;

    always_comb begin
        stp     = bit_step(cur, din);
        res.sum = stp.sum;
        res.ovf = stp.legal && (stp.pos == LAST_POS) && stp.cout;
    end
endmodule

// File: rtl/addthree_streg.sv
module addthree_streg #(
    parameter int               W       = 3,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(negedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= d;
    end
endmodule

// File: rtl/addthree_serial.sv
module addthree_serial
    import addthree_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               din,
    output logic               sum_bit,
    output logic               ovf,
    output logic [STATE_W-1:0] state_q
);
    logic [STATE_W-1:0] state_d;
    out_t               res;

    addthree_nsl u_nsl (
        .cur (state_q),
        .din (din),
        .nxt (state_d)
    );

    addthree_outl u_outl (
        .cur (state_q),
        .din (din),
        .res (res)
    );

    addthree_streg #(
        .W       (STATE_W),
        .RST_VAL (ST_P0)
    ) u_streg (
        .clk (clk),
        .rst (rst),
        .d   (state_d),
        .q   (state_q)
    );

    assign sum_bit = res.sum;
    assign ovf     = res.ovf;
endmodule

// File: rtl/addthree_chk.sv
module addthree_chk
    import addthree_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               din,
    input logic               sum_bit,
    input logic               ovf,
    input logic [STATE_W-1:0] state_q
);
    logic [POS_W-1:0] cnt;

    always_ff @(negedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + POS_W'(1);
    end

    // R2: first bit inverts the input, never overflows
    p_first_bit_r2: assert property (@(negedge clk) disable iff (rst)
        (cnt == '0) |-> (sum_bit == !din) && !ovf);

    // R5: overflow only on the last bit of a word
    p_ovf_late_r5: assert property (@(negedge clk) disable iff (rst)
        ovf |-> (cnt == LAST_POS));

    // R6: word boundary returns to the start state
    p_restart_r6: assert property (@(negedge clk) disable iff (rst)
        (cnt == LAST_POS) |=> (state_q == ST_P0));

    // R4: an overflowing sum always has a zero top bit
    p_no_overflow_r4: assert property (@(negedge clk) disable iff (rst)
        ovf |-> !sum_bit && din);

    // R1: start state is held only at word start
    p_start_r1: assert property (@(negedge clk) disable iff (rst)
        (state_q == ST_P0) |-> (cnt == '0));
endmodule

bind addthree_serial addthree_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .din     (din),
    .sum_bit (sum_bit),
    .ovf     (ovf),
    .state_q (state_q)
);

// File: tb/addthree_serial_bench.sv
module addthree_serial_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic       sum_bit;
    logic       ovf;
    logic [2:0] state_q;
    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    addthree_serial u_addthree_serial (
        .clk(clk), .rst(rst), .din(din),
        .sum_bit(sum_bit), .ovf(ovf), .state_q(state_q)
    );

    function automatic logic [3:0] exp_sum(input logic [3:0] n);
        return 4'(n + 4'd3);
    endfunction

    function automatic logic exp_ovf(input logic [3:0] n);
        return (int'(n) + 3) > 15;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // starts and ends just after a falling edge
    task automatic drive_bit(input logic b, output logic s, output logic v);
        din = b;
        @(posedge clk); #1;
        s = sum_bit;
        v = ovf;
        @(negedge clk); #1;
    endtask

    task automatic send_word(input logic [3:0] n);
        logic [3:0] got;
        logic s, v, early;
        early = 1'b0;
        got   = '0;
        for (int i = 0; i < 4; i++) begin
            drive_bit(n[i], s, v);
            got[i] = s;
            if (i == 0) check("R2 first bit", int'({s, v}), int'({~n[0], 1'b0}));
            if (i < 3) early = early | v;
            else check("R4 ovf", int'(v), int'(exp_ovf(n)));
        end
        check("R5 early ovf", int'(early), 0);
        check("R3/R6 sum", int'(got), int'(exp_sum(n)));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk); #1;
        @(negedge clk); #1;
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic s, v;
        void'($urandom(32'd2024));
        do_reset();

        // R1: start state after reset
        din = 1'b0;
        @(posedge clk); #1;
        check("R1 reset state", int'({sum_bit, ovf}), 2);
        check("R1 state", int'(state_q), 0);
        @(negedge clk); #1;
        drive_bit(1'b0, s, v);
        drive_bit(1'b0, s, v);
        drive_bit(1'b0, s, v);

        // R3 R4 R6: all values back to back
        for (int n = 0; n < 16; n++) send_word(4'(n));

        // corner words
        send_word(4'd12);
        send_word(4'd13);
        send_word(4'd15);
        send_word(4'd0);

        // R7: outputs follow din within the cycle, rising edge holds state
        din = 1'b0;
        @(posedge clk); #1;
        check("R7 din=0", int'({sum_bit, ovf}), 2);
        check("R7 rise no step", int'(state_q), 0);
        din = 1'b1;
        #1;
        check("R7 din=1", int'({sum_bit, ovf}), 0);
        @(negedge clk); #1;
        check("R7 step on fall", int'(state_q), 2);
        drive_bit(1'b1, s, v);
        drive_bit(1'b1, s, v);
        drive_bit(1'b1, s, v);
        check("R7 word 15 ovf", int'(v), 1);

        // R8: reset mid-word
        drive_bit(1'b1, s, v);
        drive_bit(1'b1, s, v);
        do_reset();
        send_word(4'd13);
        send_word(4'd2);

        // random words
        for (int k = 0; k < 60; k++) send_word(4'($urandom_range(15, 0)));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule